// File: doc/BRIEF.md
# DDR Prefetch Data Serializer

This block sits between a memory core that moves one wide word (twice the pin width) per word clock and a pin-side data bus that moves half a word on each strobe edge. On the write path it accepts a burst of wide words, sends each one as two beats (lower half first, upper half second), drives a data strobe whose edges fall in the middle of each data beat, and sends a per-byte mask with every beat. On the read path it watches an incoming strobe whose edges line up with the data transitions, captures a half word on every edge, and hands back one wide word after each pair of edges.

Everything runs on a single fast clock at four times the word rate: each data beat lasts two fast cycles, so the write strobe can change one fast cycle into a beat, which is the centre of that beat. The bidirectional strobe and data pins are split into separate input, output and enable ports. A shared burst-size field selects one, two or four wide words per access for both directions.

Top module: `ddr_prefetch_serdes`

## Requirements
- R1: While reset is held and on the first cycle after it, `dq_oe`, `dqs_oe`, `dqs_o`, `wr_take`, `rd_valid` and `rd_err` are all low.
- R2: A `wr_go` accepted when idle makes the block drive the strobe low (`dqs_oe`=1, `dqs_o`=0) for four fast cycles with `dq_oe`=0 before the first data beat.
- R3: Each wide word goes out as two beats of two fast cycles each: bits [DQ_W-1:0] on the first beat, bits [2*DQ_W-1:DQ_W] on the second.
- R4: The write strobe is centre-aligned: within a word it is low on the first fast cycle, high on the second and third, and low on the fourth.
- R5: `dm_o` carries `wr_mask[MASK_W-1:0]` with the first beat and `wr_mask[2*MASK_W-1:MASK_W]` with the second; bit i covers byte lane i (DQ bits 8i+7..8i), and a 1 means that lane must not be written.
- R6: `bl_sel` encodes the burst: 2'b00 gives one wide word, 2'b01 two, 2'b10 and 2'b11 four; `dq_oe` stays high for exactly four fast cycles per word.
- R7: `wr_take` is high in the last fast cycle of every word except the final one; the next word and mask are sampled from `wr_data`/`wr_mask` at that clock edge (the first word is sampled with `wr_go`).
- R8: After the last beat the strobe stays driven low for two fast cycles (postamble), then `dqs_oe` falls.
- R9: `wr_go` asserted while a write is in progress is ignored: the running burst's outputs and length are unchanged and no new burst follows.
- R10: With `rd_en` high, a rising strobe edge captures `dq_i` as the lower half and the next falling edge captures the upper half; `rd_valid` pulses for one cycle in the cycle after the falling edge is sampled, with `rd_word` = {upper, lower}.
- R11: Strobe edges while `rd_en` is low are ignored: they produce no `rd_valid` and leave no half word behind for the next read.
- R12: When `rd_en` falls, `rd_err` pulses for one cycle in the following cycle if a lower half is still waiting for its pair or the number of completed words differs from the burst size given by `bl_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four cycles per wide word |
| rst_n | input | 1 | Active-low synchronous reset |
| bl_sel | input | 2 | Burst size select for both directions |
| wr_go | input | 1 | Start a write burst (sampled when idle) |
| wr_data | input | 2*DQ_W | Wide write word |
| wr_mask | input | 2*MASK_W | Per-lane block bits for the two beats |
| wr_take | output | 1 | Next wide word is sampled at this edge |
| dq_o | output | DQ_W | Pin-side write data |
| dq_oe | output | 1 | Drive enable for the data pins |
| dm_o | output | MASK_W | Pin-side write mask |
| dqs_o | output | 1 | Strobe value driven on writes |
| dqs_oe | output | 1 | Drive enable for the strobe pin |
| rd_en | input | 1 | Read capture window |
| dqs_i | input | 1 | Strobe received on reads |
| dq_i | input | DQ_W | Pin-side read data |
| rd_word | output | 2*DQ_W | Reassembled wide read word |
| rd_valid | output | 1 | One-cycle pulse, `rd_word` is new |
| rd_err | output | 1 | One-cycle pulse, read window closed on a partial burst |

## Verification
The bench uses the default DQ_W of 16, so each beat carries two mask lanes and each wide word is 32 bits; this makes lane order inside `dm_o` and the half-word order on both paths visible in every beat. Every burst-size code, including the reserved 2'b11, is walked on the write path, which brings the word-to-word `wr_take` handover and the four-word burst within reach. The read path is driven with a full burst, a trailing lone rising edge, a short word count and strobe activity outside the window.

// File: rtl/ddr_sd_pkg.sv
`timescale 1ns/1ps
package ddr_sd_pkg;

  typedef enum logic [1:0] {
    WS_IDLE,
    WS_PRE,
    WS_DATA,
    WS_POST
  } wr_state_e;

  // Number of wide words in one access for a burst-size code.
  function automatic logic [2:0] words_per_burst(input logic [1:0] sel);
    case (sel)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // Centre-aligned write strobe level for a fast-cycle phase within a word.
  function automatic logic centre_strobe(input logic [1:0] phase);
    return phase[0] ^ phase[1];
  endfunction

  // Upper beat is selected in the second half of a word.
  function automatic logic upper_beat(input logic [1:0] phase);
    return phase[1];
  endfunction

endpackage

// File: rtl/ddr_wr_serializer.sv
`timescale 1ns/1ps
module ddr_wr_serializer
  import ddr_sd_pkg::*;
#(
  parameter int DQ_W   = 16,
  parameter int MASK_W = DQ_W / 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            bl_sel,
  input  logic                  wr_go,
  input  logic [2*DQ_W-1:0]     wr_data,
  input  logic [2*MASK_W-1:0]   wr_mask,
  output logic                  wr_take,
  output logic [DQ_W-1:0]       dq_o,
  output logic                  dq_oe,
  output logic [MASK_W-1:0]     dm_o,
  output logic                  dqs_o,
  output logic                  dqs_oe
);

  localparam int WORD_W = 2 * DQ_W;
  localparam int WM_W   = 2 * MASK_W;

  wr_state_e          st_q;
  logic [1:0]         cyc_q;
  logic [2:0]         widx_q;
  logic [2:0]         nwords_q;
  logic [WORD_W-1:0]  word_q;
  logic [WM_W-1:0]    mask_q;

  // Named internal events
  logic in_data;
  logic word_end;
  logic last_word;
  logic hi_beat;

  assign in_data   = (st_q == WS_DATA);
  assign word_end  = (cyc_q == 2'd3);
  assign last_word = (widx_q == nwords_q - 3'd1);
  assign hi_beat   = upper_beat(cyc_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= WS_IDLE;
      cyc_q    <= '0;
      widx_q   <= '0;
      nwords_q <= 3'd1;
      word_q   <= '0;
      mask_q   <= '0;
    end else begin
      case (st_q)
        WS_IDLE: begin
          if (wr_go) begin
            st_q     <= WS_PRE;
            cyc_q    <= '0;
            widx_q   <= '0;
            nwords_q <= words_per_burst(bl_sel);
            word_q   <= wr_data;
            mask_q   <= wr_mask;
          end
        end
        WS_PRE: begin
          cyc_q <= cyc_q + 2'd1;
          if (word_end) st_q <= WS_DATA;
        end
        WS_DATA: begin
          cyc_q <= cyc_q + 2'd1;
          if (word_end) begin
            if (last_word) begin
              st_q <= WS_POST;
            end else begin
              widx_q <= widx_q + 3'd1;
              word_q <= wr_data;
              mask_q <= wr_mask;
            end
          end
        end
        default: begin
          if (cyc_q == 2'd1) begin
            st_q  <= WS_IDLE;
            cyc_q <= '0;
          end else begin
            cyc_q <= cyc_q + 2'd1;
          end
        end
      endcase
    end
  end

  always_comb begin
    wr_take = in_data && word_end && !last_word;
    dq_oe   = in_data;
    dqs_oe  = (st_q != WS_IDLE);
    dqs_o   = in_data ? centre_strobe(cyc_q) : 1'b0;
    dq_o    = '0;
    dm_o    = '0;
    if (in_data) begin
      dq_o = hi_beat ? word_q[WORD_W-1:DQ_W] : word_q[DQ_W-1:0];
      dm_o = hi_beat ? mask_q[WM_W-1:MASK_W] : mask_q[MASK_W-1:0];
    end
  end

  AST_DQ_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> dqs_oe); // R2
  AST_PREAMBLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> ($past(dqs_oe) && !$past(dqs_o))); // R2
  AST_POSTAMBLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> (dqs_oe && !dqs_o)); // R8
  AST_TAKE_MIDBURST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> (dq_oe && !wr_take)); // R7
  AST_STROBE_RISE_IN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dqs_o) |-> ($past(dq_oe) && dq_oe)); // R4

endmodule

// File: rtl/ddr_rd_deserializer.sv
`timescale 1ns/1ps
module ddr_rd_deserializer
  import ddr_sd_pkg::*;
#(
  parameter int DQ_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bl_sel,
  input  logic              rd_en,
  input  logic              dqs_i,
  input  logic [DQ_W-1:0]   dq_i,
  output logic [2*DQ_W-1:0] rd_word,
  output logic              rd_valid,
  output logic              rd_err
);

  logic              dqs_q;
  logic              rd_en_q;
  logic              half_q;
  logic [DQ_W-1:0]   lo_q;
  logic [2:0]        cnt_q;

  // Named internal events
  logic rise_e;
  logic fall_e;
  logic win_close;
  logic partial;

  assign rise_e    = rd_en &&  dqs_i && !dqs_q;
  assign fall_e    = rd_en && !dqs_i &&  dqs_q;
  assign win_close = !rd_en && rd_en_q;
  assign partial   = half_q || (cnt_q != words_per_burst(bl_sel));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dqs_q    <= 1'b0;
      rd_en_q  <= 1'b0;
      half_q   <= 1'b0;
      lo_q     <= '0;
      cnt_q    <= '0;
      rd_word  <= '0;
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
    end else begin
      dqs_q    <= dqs_i;
      rd_en_q  <= rd_en;
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
      if (!rd_en) begin
        if (win_close) rd_err <= partial;
        half_q <= 1'b0;
        cnt_q  <= '0;
      end else if (rise_e) begin
        lo_q   <= dq_i;
        half_q <= 1'b1;
      end else if (fall_e && half_q) begin
        rd_word  <= {dq_i, lo_q};
        rd_valid <= 1'b1;
        half_q   <= 1'b0;
        if (cnt_q != 3'd7) cnt_q <= cnt_q + 3'd1;
      end
    end
  end

  AST_VALID_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R10
  AST_VALID_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en)); // R11
  AST_ERR_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (!$past(rd_en) && $past(rd_en, 2))); // R12

endmodule

// File: rtl/ddr_prefetch_serdes.sv
`timescale 1ns/1ps
module ddr_prefetch_serdes #(
  parameter int DQ_W   = 16,
  parameter int MASK_W = DQ_W / 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          bl_sel,
  input  logic                wr_go,
  input  logic [2*DQ_W-1:0]   wr_data,
  input  logic [2*MASK_W-1:0] wr_mask,
  output logic                wr_take,
  output logic [DQ_W-1:0]     dq_o,
  output logic                dq_oe,
  output logic [MASK_W-1:0]   dm_o,
  output logic                dqs_o,
  output logic                dqs_oe,
  input  logic                rd_en,
  input  logic                dqs_i,
  input  logic [DQ_W-1:0]     dq_i,
  output logic [2*DQ_W-1:0]   rd_word,
  output logic                rd_valid,
  output logic                rd_err
);

  ddr_wr_serializer #(.DQ_W(DQ_W), .MASK_W(MASK_W)) u_wr (
    .clk     (clk),
    .rst_n   (rst_n),
    .bl_sel  (bl_sel),
    .wr_go   (wr_go),
    .wr_data (wr_data),
    .wr_mask (wr_mask),
    .wr_take (wr_take),
    .dq_o    (dq_o),
    .dq_oe   (dq_oe),
    .dm_o    (dm_o),
    .dqs_o   (dqs_o),
    .dqs_oe  (dqs_oe)
  );

  ddr_rd_deserializer #(.DQ_W(DQ_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .bl_sel   (bl_sel),
    .rd_en    (rd_en),
    .dqs_i    (dqs_i),
    .dq_i     (dq_i),
    .rd_word  (rd_word),
    .rd_valid (rd_valid),
    .rd_err   (rd_err)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!dq_oe && !dqs_oe && !rd_valid && !rd_err)); // R1

endmodule

// File: tb/tb_ddr_prefetch_serdes.sv
`timescale 1ns/1ps
module tb_ddr_prefetch_serdes;

  localparam int DQ_W = 16;
  localparam int MK_W = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      bl_sel = 2'b00;
  logic            wr_go = 1'b0;
  logic [31:0]     wr_data = '0;
  logic [3:0]      wr_mask = '0;
  logic            wr_take;
  logic [15:0]     dq_o;
  logic            dq_oe;
  logic [1:0]      dm_o;
  logic            dqs_o;
  logic            dqs_oe;
  logic            rd_en = 1'b0;
  logic            dqs_i = 1'b0;
  logic [15:0]     dq_i = '0;
  logic [31:0]     rd_word;
  logic            rd_valid;
  logic            rd_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ddr_prefetch_serdes #(.DQ_W(DQ_W), .MASK_W(MK_W)) dut (
    .clk(clk), .rst_n(rst_n), .bl_sel(bl_sel), .wr_go(wr_go),
    .wr_data(wr_data), .wr_mask(wr_mask), .wr_take(wr_take),
    .dq_o(dq_o), .dq_oe(dq_oe), .dm_o(dm_o), .dqs_o(dqs_o),
    .dqs_oe(dqs_oe), .rd_en(rd_en), .dqs_i(dqs_i), .dq_i(dq_i),
    .rd_word(rd_word), .rd_valid(rd_valid), .rd_err(rd_err)
  );

  task automatic check(input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] word_of(input logic [31:0] seed, input int k);
    return seed + 32'h1357_9BDF * k;
  endfunction

  function automatic logic [3:0] mask_of(input logic [3:0] ms, input int k);
    return ms ^ 4'(k * 5);
  endfunction

  // {bl_sel[1:0], seed[31:0], mask seed[3:0], poke busy wr_go}
  localparam logic [38:0] VEC [6] = '{
    {2'b00, 32'hA5C3_0F1E, 4'b0110, 1'b0},
    {2'b01, 32'h1234_5678, 4'b1001, 1'b0},
    {2'b10, 32'hDEAD_BEEF, 4'b0011, 1'b0},
    {2'b11, 32'h0F0F_F0F0, 4'b1100, 1'b0},
    {2'b00, 32'h8001_7FFE, 4'b1111, 1'b1},
    {2'b01, 32'hFFFF_0000, 4'b0000, 1'b1}
  };

  task automatic run_write(input logic [1:0] bl, input logic [31:0] seed,
                           input logic [3:0] ms, input bit poke);
    int nw;
    int last_n;
    nw = (bl == 2'b00) ? 1 : (bl == 2'b01) ? 2 : 4;
    last_n = 4 + 4 * nw + 2;
    @(negedge clk);
    wr_go = 1'b1; bl_sel = bl;
    wr_data = word_of(seed, 0); wr_mask = mask_of(ms, 0);
    @(negedge clk);
    wr_go = 1'b0;
    for (int n = 0; n <= last_n; n++) begin
      if (n < 4) begin
        check("R2 preamble", {61'd0, dqs_oe, dqs_o, dq_oe}, {61'd0, 3'b100});
      end else if (n < 4 + 4 * nw) begin
        int k;
        int s;
        logic [31:0] w;
        logic [3:0] m;
        k = (n - 4) / 4;
        s = (n - 4) % 4;
        w = word_of(seed, k);
        m = mask_of(ms, k);
        check("R6 data window", {62'd0, dqs_oe, dq_oe}, {62'd0, 2'b11});
        check("R3 beat order", {48'd0, dq_o}, {48'd0, (s >= 2) ? w[31:16] : w[15:0]});
        check("R4 centred strobe", {63'd0, dqs_o}, {63'd0, (s == 1 || s == 2)});
        check("R5 mask lanes", {62'd0, dm_o}, {62'd0, (s >= 2) ? m[3:2] : m[1:0]});
        check("R7 take", {63'd0, wr_take}, {63'd0, (s == 3 && k < nw - 1)});
        if (s == 3 && k < nw - 1) begin
          wr_data = word_of(seed, k + 1);
          wr_mask = mask_of(ms, k + 1);
        end
      end else if (n < last_n) begin
        check("R8 postamble", {61'd0, dqs_oe, dqs_o, dq_oe}, {61'd0, 3'b100});
      end else begin
        check(poke ? "R9 no restart" : "R8 release",
              {61'd0, dqs_oe, dq_oe, wr_take}, 64'd0);
      end
      if (poke && n == 1) begin
        wr_go = 1'b1; wr_data = ~seed; wr_mask = ~ms; bl_sel = 2'b10;
      end else begin
        wr_go = 1'b0;
      end
      if (poke && n == 2) bl_sel = bl;
      @(negedge clk);
    end
    check("R9 stays idle", {62'd0, dqs_oe, dq_oe}, 64'd0);
  endtask

  // Drives nw full words then an optional lone rising edge, then closes.
  task automatic run_read(input logic [1:0] bl, input int nw,
                          input logic [31:0] seed, input bit lone_rise,
                          input bit exp_err);
    logic [31:0] w;
    @(negedge clk);
    bl_sel = bl; rd_en = 1'b1; dqs_i = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < nw; k++) begin
      w = word_of(seed, k);
      dqs_i = 1'b1; dq_i = w[15:0];
      @(negedge clk);
      check("R10 no early valid", {63'd0, rd_valid}, 64'd0);
      @(negedge clk);
      dqs_i = 1'b0; dq_i = w[31:16];
      @(negedge clk);
      check("R10 word valid", {31'd0, rd_valid, rd_word}, {31'd0, 1'b1, w});
      @(negedge clk);
      check("R10 single pulse", {63'd0, rd_valid}, 64'd0);
    end
    if (lone_rise) begin
      dqs_i = 1'b1; dq_i = 16'hBEEF;
      @(negedge clk);
      @(negedge clk);
    end
    rd_en = 1'b0; dqs_i = 1'b0;
    @(negedge clk);
    check("R12 err at close", {62'd0, rd_valid, rd_err}, {62'd0, 1'b0, exp_err});
    @(negedge clk);
    check("R12 err pulse", {63'd0, rd_err}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset held", {58'd0, dq_oe, dqs_oe, dqs_o, wr_take, rd_valid, rd_err}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {58'd0, dq_oe, dqs_oe, dqs_o, wr_take, rd_valid, rd_err}, 64'd0);

    for (int v = 0; v < 6; v++) begin
      run_write(VEC[v][38:37], VEC[v][36:5], VEC[v][4:1], VEC[v][0]);
    end

    run_read(2'b01, 2, 32'hCAFE_1234, 1'b0, 1'b0);
    run_read(2'b10, 4, 32'h0BAD_F00D, 1'b0, 1'b0);
    run_read(2'b01, 1, 32'h5555_AAAA, 1'b1, 1'b1);
    run_read(2'b01, 1, 32'h7777_8888, 1'b0, 1'b1);

    // R11: strobe activity outside the window
    @(negedge clk);
    rd_en = 1'b0;
    for (int t = 0; t < 6; t++) begin
      dqs_i = ~dqs_i; dq_i = 16'h1111 * t[15:0];
      @(negedge clk);
      check("R11 ignored edge", {62'd0, rd_valid, rd_err}, 64'd0);
    end
    dqs_i = 1'b0;
    @(negedge clk);
    run_read(2'b00, 1, 32'h2468_ACE0, 1'b0, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule